// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 27 input pins that are split into four groups and raises one interrupt request per group. Any level change, rising or falling, on a pin whose mask bit is set marks that pin's group by setting a sticky flag. Each flag stays set until software writes a one to it or the processor acknowledges that group's vector.

Every pin passes through a two-stage synchroniser before change detection. A group enable register and a global interrupt enable input decide which flags go on to drive the request outputs. A simple register port gives access to the flags, the enables and the four mask registers. Reads are combinational from the address, and writes take effect on the clock edge that samples the write strobe.

Top module: `grouped_change_irq`

## Requirements
- R1: Pins 7..0 map to group 0, pins 15..8 to group 1, pins 23..16 to group 2 and pins 26..24 to group 3. Group g owns flag bit g, and mask register g holds pin 8g+i at bit i.
- R2: A change in either direction on a pin whose mask bit is set sets its group flag. The flag becomes readable at the third rising clock edge after the pin changes, counting the edge that first samples the new level as the first.
- R3: irqReq[g] is a registered copy of flag[g] AND enable[g] AND globalIntEn, so it follows them one clock later. It is zero whenever globalIntEn was zero on the previous edge.
- R4: A one-cycle pulse on bit g of vecAck clears flag g only. The other flags keep their values.
- R5: Writing to the flag address clears each flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R6: A pin whose mask bit is zero never sets its group flag.
- R7: Flag register bits 7..4 and group 3 mask bits 7..3 always read as zero, and writes to them have no effect.
- R8: After reset, all flags, enables, masks and requests are zero.
- R9: If a qualifying change and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R10: Register addresses are 0 for flags, 1 for group enables (bits 3..0), and 2, 3, 4, 5 for the masks of groups 0, 1, 2, 3. Addresses 6 and 7 read as zero. Enable and mask registers read back what was written, apart from the bits that R7 reserves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 27 | Watched pins, asynchronous to clk |
| globalIntEn | input | 1 | Global interrupt enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| vecAck | input | 4 | One-hot vector acknowledge pulse, one bit per group |
| irqReq | output | 4 | Registered interrupt request, one bit per group |

## Verification
Single pins are toggled at the lowest and highest position of each group, including pin 26. This separates a correct group mapping from an off-by-one mapping at the group edges. One pin is driven high and then low again, which tells an any-change detector apart from one that only sees rising edges. A masked pin is toggled next to an unmasked pin of the same group, which shows that masking works per pin and not per group. In another test, a pin change is timed so that it reaches the flag in the same cycle as an acknowledge, or as a write-one. This separates set-wins priority from clear-wins priority.

// File: rtl/pcic_pkg.sv
package pcic_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int MAX_GRP   = 4;
  localparam int GRP_SEL_W = $clog2(MAX_GRP);

  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK0 = 3'd2;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_FLAG = 2'd1,
    RD_EN   = 2'd2,
    RD_MASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                 flagClr;
    logic                 enLoad;
    logic [MAX_GRP-1:0]   maskLoad;
    logic [DATA_W-1:0]    data;
    rdSel_e               rdSel;
    logic [GRP_SEL_W-1:0] rdGrp;
  } ctrlStrb_t;

endpackage

// File: rtl/pcic_ctrl.sv
module pcic_ctrl
  import pcic_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrb_t         strb
);

  always_comb begin
    strb       = '0;
    strb.data  = regWrData;
    strb.rdSel = RD_NONE;
    if (regAddr == ADDR_FLAG) begin
      strb.rdSel   = RD_FLAG;
      strb.flagClr = regWrEn;
    end else if (regAddr == ADDR_EN) begin
      strb.rdSel  = RD_EN;
      strb.enLoad = regWrEn;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (regAddr == ADDR_MASK0 + ADDR_W'(g)) begin
          strb.rdSel       = RD_MASK;
          strb.rdGrp       = GRP_SEL_W'(g);
          strb.maskLoad[g] = regWrEn;
        end
      end
    end
  end

endmodule

// File: rtl/pcic_datapath.sv
module pcic_datapath
  import pcic_pkg::*;
#(
  parameter int NUM_PINS    = 27,
  parameter int NG          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                globalIntEn,
  input  logic [NG-1:0]       vecAck,
  input  ctrlStrb_t           strb,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NG-1:0]       irqReq,
  output logic [NG-1:0]       flagQ,
  output logic [NG-1:0]       maskAny
);

  localparam int PAD_W = NG * DATA_W;
  localparam logic [PAD_W-1:0] VALID = PAD_W'({NUM_PINS{1'b1}});

  // synchroniser chain
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] chg;
  logic [PAD_W-1:0]    chgPad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign chg    = syncQ[SYNC_STAGES-1] ^ prevQ;
  assign chgPad = PAD_W'(chg);

  // mask registers and per-group hit
  logic [NG-1:0][DATA_W-1:0] maskQ;
  logic [NG-1:0]             grpHit;

  for (genvar g = 0; g < NG; g++) begin : gGrp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                maskQ[g] <= '0;
      else if (strb.maskLoad[g]) maskQ[g] <= strb.data & VALID[g*DATA_W +: DATA_W];
    end
    assign grpHit[g]  = |(chgPad[g*DATA_W +: DATA_W] & maskQ[g]);
    assign maskAny[g] = |maskQ[g];
  end

  // group enables
  logic [NG-1:0] enQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enQ <= '0;
    else if (strb.enLoad) enQ <= strb.data[NG-1:0];
  end

  // sticky flags: a new hit outranks any clear in the same cycle
  logic [NG-1:0] clrVec;
  assign clrVec = (strb.flagClr ? strb.data[NG-1:0] : '0) | vecAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrVec) | grpHit;
  end

  // registered request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqReq <= '0;
    else       irqReq <= flagQ & enQ & {NG{globalIntEn}};
  end

  // read mux
  always_comb begin
    regRdData = '0;
    case (strb.rdSel)
      RD_FLAG: regRdData = DATA_W'(flagQ);
      RD_EN:   regRdData = DATA_W'(enQ);
      RD_MASK: regRdData = maskQ[strb.rdGrp];
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/grouped_change_irq.sv
module grouped_change_irq
  import pcic_pkg::*;
#(
  parameter int NUM_PINS    = 27,
  parameter int SYNC_STAGES = 2,
  localparam int NG         = (NUM_PINS + DATA_W - 1) / DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                globalIntEn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NG-1:0]       vecAck,
  output logic [NG-1:0]       irqReq
);

  ctrlStrb_t     strb;
  logic [NG-1:0] flagQ;
  logic [NG-1:0] maskAny;

  pcic_ctrl #(.NG(NG)) u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  pcic_datapath #(
    .NUM_PINS    (NUM_PINS),
    .NG          (NG),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pinIn       (pinIn),
    .globalIntEn (globalIntEn),
    .vecAck      (vecAck),
    .strb        (strb),
    .regRdData   (regRdData),
    .irqReq      (irqReq),
    .flagQ       (flagQ),
    .maskAny     (maskAny)
  );

endmodule

// File: rtl/pcic_checker.sv
module pcic_checker
  import pcic_pkg::*;
#(
  parameter int NG = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalIntEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic [NG-1:0]     irqReq,
  input logic [NG-1:0]     flagQ,
  input logic [NG-1:0]     maskAny
);

  AST_RSVD_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_FLAG) |-> (regRdData[DATA_W-1:NG] == '0)); // R7

  AST_RSVD_MASK3_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd5) |-> (regRdData[DATA_W-1:3] == '0)); // R7

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    !globalIntEn |=> (irqReq == '0)); // R3

  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~$past(flagQ)) == '0); // R3

  AST_NO_SET_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ & ~$past(flagQ) & ~$past(maskAny)) == '0); // R6

endmodule

bind grouped_change_irq pcic_checker #(.NG(NG)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .globalIntEn (globalIntEn),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .irqReq      (irqReq),
  .flagQ       (flagQ),
  .maskAny     (maskAny)
);

// File: tb/tb_grouped_change_irq.sv
module tb_grouped_change_irq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [26:0] pinIn = '0;
  logic        globalIntEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [3:0]  vecAck = '0;
  logic [3:0]  irqReq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  grouped_change_irq dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIntEn(globalIntEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .vecAck(vecAck), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic toggle(input int p);
    @(negedge clk);
    pinIn[p] = ~pinIn[p];
  endtask

  task automatic cleanSlate();
    wr(3'd0, 8'hFF);
    for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'h00);
    wr(3'd1, 8'h00);
    globalIntEn = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R8 reset reg", {24'd0, d}, 32'd0);
    end
    chk("R8 reset irq", {28'd0, irqReq}, 32'd0);
  endtask

  task automatic tGroupMap();
    logic [7:0] d;
    int pins[8] = '{0, 7, 8, 15, 16, 23, 24, 26};
    for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'hFF);
    foreach (pins[i]) begin
      wr(3'd0, 8'hFF);
      toggle(pins[i]);
      tick(4);
      rd(3'd0, d);
      chk("R1 group map", {24'd0, d}, 32'(1 << (pins[i] / 8)));
    end
    cleanSlate();
  endtask

  task automatic tTiming();
    logic [7:0] d;
    wr(3'd2, 8'h08);
    toggle(3);
    tick(2);
    #1 regAddr = 3'd0;
    #1 chk("R2 not yet set after two edges", {24'd0, regRdData}, 32'd0);
    tick(1);
    #1 chk("R2 set at third edge", {24'd0, regRdData}, 32'd1);
    wr(3'd0, 8'h01);
    toggle(3);
    tick(4);
    rd(3'd0, d);
    chk("R2 falling change sets flag", {24'd0, d}, 32'd1);
    cleanSlate();
  endtask

  task automatic tMask();
    logic [7:0] d;
    wr(3'd2, 8'hFE);
    toggle(0);
    tick(4);
    rd(3'd0, d);
    chk("R6 masked pin ignored", {24'd0, d}, 32'd0);
    toggle(1);
    tick(4);
    rd(3'd0, d);
    chk("R6 unmasked neighbour sets", {24'd0, d}, 32'd1);
    cleanSlate();
  endtask

  task automatic tWriteClear();
    logic [7:0] d;
    wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);
    toggle(2); toggle(17);
    tick(4);
    wr(3'd0, 8'h00);
    rd(3'd0, d);
    chk("R5 write zero keeps flags", {24'd0, d}, 32'h5);
    wr(3'd0, 8'h01);
    rd(3'd0, d);
    chk("R5 write one clears only bit0", {24'd0, d}, 32'h4);
    cleanSlate();
  endtask

  task automatic tAck();
    logic [7:0] d;
    for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'hFF);
    toggle(4); toggle(12); toggle(20); toggle(25);
    tick(4);
    @(negedge clk); vecAck = 4'b0010;
    @(negedge clk); vecAck = 4'b0000;
    rd(3'd0, d);
    chk("R4 ack clears own flag only", {24'd0, d}, 32'hD);
    cleanSlate();
  endtask

  task automatic tIrq();
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h0F);
    toggle(9);
    tick(5);
    chk("R3 no request while global enable low", {28'd0, irqReq}, 32'd0);
    @(negedge clk); globalIntEn = 1'b1;
    tick(1);
    chk("R3 request one cycle after enable", {28'd0, irqReq}, 32'h2);
    wr(3'd1, 8'h0D);
    tick(1);
    chk("R3 group enable gates request", {28'd0, irqReq}, 32'd0);
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'h02);
    tick(1);
    chk("R3 request drops after flag clear", {28'd0, irqReq}, 32'd0);
    cleanSlate();
  endtask

  task automatic tSetWins();
    logic [7:0] d;
    wr(3'd2, 8'hFF);
    toggle(5);
    tick(4);
    toggle(5);
    tick(1);
    @(negedge clk); vecAck = 4'b0001;
    @(negedge clk); vecAck = 4'b0000;
    rd(3'd0, d);
    chk("R9 change beats acknowledge", {24'd0, d}, 32'd1);
    toggle(5);
    tick(1);
    wr(3'd0, 8'h01);
    rd(3'd0, d);
    chk("R9 change beats write-one", {24'd0, d}, 32'd1);
    cleanSlate();
  endtask

  task automatic tReserved();
    logic [7:0] d;
    wr(3'd5, 8'hFF);
    rd(3'd5, d);
    chk("R7 group3 mask upper bits zero", {24'd0, d}, 32'h07);
    for (int g = 0; g < 3; g++) wr(3'(2 + g), 8'hFF);
    toggle(6);
    tick(4);
    wr(3'd0, 8'hF0);
    rd(3'd0, d);
    chk("R7 flag upper bits zero, write ignored", {24'd0, d}, 32'h01);
    cleanSlate();
  endtask

  task automatic tRegMap();
    logic [7:0] d;
    wr(3'd1, 8'h0A); wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h05);
    rd(3'd1, d); chk("R10 enable readback", {24'd0, d}, 32'h0A);
    rd(3'd2, d); chk("R10 mask0 readback", {24'd0, d}, 32'h11);
    rd(3'd3, d); chk("R10 mask1 readback", {24'd0, d}, 32'h22);
    rd(3'd4, d); chk("R10 mask2 readback", {24'd0, d}, 32'h33);
    rd(3'd5, d); chk("R10 mask3 readback", {24'd0, d}, 32'h05);
    rd(3'd6, d); chk("R10 addr6 reads zero", {24'd0, d}, 32'd0);
    rd(3'd7, d); chk("R10 addr7 reads zero", {24'd0, d}, 32'd0);
    cleanSlate();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tGroupMap();
    tTiming();
    tMask();
    tWriteClear();
    tAck();
    tIrq();
    tSetWins();
    tReserved();
    tRegMap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule